// File: doc/BRIEF.md
# Multiplexed Bus Peripheral Bridge

This block sits inside programmable logic as a slave on a host bus where one 32-bit set of wires carries first an address and then data. While the address-latch strobe is high the block captures the word-select bits of the address. While its own active-low chip select is low it serves one access. A read drives register data onto the bus only while output-enable is low. A write stores the byte lanes chosen by four active-low byte write enables. The block ends each access itself with a one-cycle active-low acknowledge, so the host does not need to count wait states.

Behind the bus sits a small bank of four word registers. The first is a general control word whose bit 0 gates the interrupt output. The second holds a 4-bit serial-peripheral select code that is decoded into one memory select line and seven external select lines. The third holds sticky interrupt flags, cleared by writing ones. The fourth holds a mask of the flags that may raise the active-low interrupt line.

The bus is split into an input word `ad_i` and an output word `ad_o` with its own drive enable `ad_oe`, so the pad tristate stays outside the block. All bus inputs are taken as synchronous to `clk`.

Top module: `mbb_bridge`

## Requirements
- R1: The register index is taken from address bits [3:2] on each clock edge where `ale` is high. Later bus values do not change it, and address bits outside [3:2] are ignored, so addresses alias every 16 bytes.
- R2: `ad_oe` is high only while `rst_n` is high, `cs_n` is low, `rnw` is high and `oe_n` is low. It is low throughout reset whatever the bus controls do, and `ad_o` is zero whenever `ad_oe` is low.
- R3: Take the first clock edge of an access at which `cs_n` is low and either (`rnw` high and `oe_n` low) or (`rnw` low and any `bwe_n` bit low). `ta_n` is low for exactly the one cycle after that edge. It does not go low again until `cs_n` has been high.
- R4: A write changes only the byte lanes whose `bwe_n` bit is low. `bwe_n[k]` guards data bits [8k+7:8k].
- R5: Offsets 0x0 (control, 32 bits) and 0xC (interrupt mask, bits [7:0]) read back what was written. The select code at offset 0x4 reads back in bits [3:0]. Unused bits read as zero, and every register resets to zero.
- R6: The select code decodes as follows. Code 0 and codes 9 to 15 drive no select line. Code 1 drives `ee_sel_n` low. Code n from 2 to 8 drives `ext_sel_n[n-2]` low. At most one select line is low at any time.
- R7: A high bit of `irq_evt` at a clock edge sets the matching flag at offset 0x8. A flag stays set until a write of 1 to that bit at offset 0x8 clears it. If a set and a clear of the same flag fall on the same edge, the set wins.
- R8: `irq_n` is low exactly when control bit 0 is 1 and some flag is set whose mask bit is also 1. It follows the register contents with no added cycle.
- R9: With `cs_n` high, write enables and output-enable have no effect: no register changes and `ta_n` stays high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| ad_i | input | 32 | Multiplexed address/data word from the host |
| ad_o | output | 32 | Read data toward the host |
| ad_oe | output | 1 | Drive enable for `ad_o` onto the shared bus |
| ale | input | 1 | Address latch strobe, active high |
| cs_n | input | 1 | Chip select of this block, active low |
| rnw | input | 1 | Cycle direction: 1 read, 0 write |
| oe_n | input | 1 | Output enable, active low |
| bwe_n | input | 4 | Byte write enables, active low, one per lane |
| ta_n | output | 1 | Transfer acknowledge, active low |
| irq_n | output | 1 | Interrupt request to the CPU, active low |
| irq_evt | input | 8 | Interrupt event pulses, one per flag |
| ee_sel_n | output | 1 | Memory device select, active low |
| ext_sel_n | output | 7 | External peripheral selects, active low |

## Verification
A wrong latched index shows on the very next read as data from the wrong register, so each access is followed by a read through a separately aliased address. A stuck or repeated completion flag shows within one cycle as a missing or doubled acknowledge pulse. A wrong lane mask or a lost flag shows on the following readback or on the select and interrupt pins in the cycle after the write edge. Each of these is sampled at the half cycle after the edge that should have changed it.

// File: rtl/mbb_pkg.sv
package mbb_pkg;
  typedef enum logic [1:0] {
    REG_CTRL = 2'd0,
    REG_SEL  = 2'd1,
    REG_ISR  = 2'd2,
    REG_IER  = 2'd3
  } reg_idx_e;

  localparam int unsigned IDX_LSB = 2;
  localparam int unsigned IDX_W   = 2;
endpackage

// File: rtl/mbb_bus_ctrl.sv
module mbb_bus_ctrl
  import mbb_pkg::*;
#(
  parameter int unsigned DW = 32,
  localparam int unsigned NB = DW / 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [DW-1:0] ad_i,
  input  logic          ale,
  input  logic          cs_n,
  input  logic          rnw,
  input  logic          oe_n,
  input  logic [NB-1:0] bwe_n,
  output reg_idx_e      idx,
  output logic          wr_stb,
  output logic [NB-1:0] wr_be,
  output logic [DW-1:0] wr_data,
  output logic          drive_en,
  output logic          ta_n
);
  reg_idx_e idx_q;
  logic     done_q;
  logic     ta_q;
  logic     access;
  logic     start;

  // Address phase: word index held until the next strobe
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)   idx_q <= REG_CTRL;
    else if (ale) idx_q <= reg_idx_e'(ad_i[IDX_LSB +: IDX_W]);
  end

  assign access = !cs_n && ((rnw && !oe_n) || (!rnw && !(&bwe_n)));
  assign start  = access && !done_q;

  // One acknowledge per chip-select assertion
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      done_q <= 1'b0;
      ta_q   <= 1'b0;
    end else begin
      done_q <= cs_n ? 1'b0 : (done_q || start);
      ta_q   <= start;
    end
  end

  assign idx      = idx_q;
  assign wr_stb   = start && !rnw;
  assign wr_be    = ~bwe_n;
  assign wr_data  = ad_i;
  assign drive_en = rst_n && !cs_n && rnw && !oe_n;
  assign ta_n     = !ta_q;

  // R3: acknowledge lasts one cycle
  assert_ta_single_R3: assert property (@(posedge clk) disable iff (!rst_n)
    !ta_n |=> ta_n);
  // R3, R9: acknowledge only follows a selected cycle
  assert_ta_needs_cs_R9: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(ta_n) |-> $past(!cs_n));
  // R3: no second acknowledge while chip select stays low
  assert_ta_once_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (!ta_n && !cs_n) |=> (cs_n || ta_n));
endmodule

// File: rtl/mbb_sel_decode.sv
module mbb_sel_decode #(
  parameter int unsigned CODE_W  = 4,
  parameter int unsigned NUM_EXT = 7
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic [CODE_W-1:0]  code,
  output logic               ee_sel_n,
  output logic [NUM_EXT-1:0] ext_sel_n
);
  localparam int unsigned EE_CODE  = 1;
  localparam int unsigned EXT_BASE = 2;

  assign ee_sel_n = !(code == CODE_W'(EE_CODE));

  for (genvar i = 0; i < NUM_EXT; i++) begin : g_ext
    assign ext_sel_n[i] = !(code == CODE_W'(EXT_BASE + i));
  end

  // R6: never two selects at once
  assert_sel_onehot_R6: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(~{ee_sel_n, ext_sel_n}));
endmodule

// File: rtl/mbb_regs.sv
module mbb_regs
  import mbb_pkg::*;
#(
  parameter int unsigned DW      = 32,
  parameter int unsigned NUM_IRQ = 8,
  parameter int unsigned SEL_W   = 4,
  localparam int unsigned NB     = DW / 8
) (
  input  logic               clk,
  input  logic               rst_n,
  input  reg_idx_e           idx,
  input  logic               wr_stb,
  input  logic [NB-1:0]      wr_be,
  input  logic [DW-1:0]      wr_data,
  input  logic [NUM_IRQ-1:0] irq_evt,
  output logic [DW-1:0]      rd_data,
  output logic [SEL_W-1:0]   sel_code,
  output logic               irq_n
);
  logic [DW-1:0]      ctrl_q;
  logic [SEL_W-1:0]   sel_q;
  logic [NUM_IRQ-1:0] isr_q;
  logic [NUM_IRQ-1:0] ier_q;
  logic [DW-1:0]      bmask;
  logic [NUM_IRQ-1:0] clr;
  logic               wr_ctrl, wr_sel, wr_isr, wr_ier;

  for (genvar b = 0; b < DW; b++) begin : g_mask
    assign bmask[b] = wr_be[b / 8];
  end

  assign wr_ctrl = wr_stb && (idx == REG_CTRL);
  assign wr_sel  = wr_stb && (idx == REG_SEL) && wr_be[0];
  assign wr_isr  = wr_stb && (idx == REG_ISR);
  assign wr_ier  = wr_stb && (idx == REG_IER);
  assign clr     = wr_isr ? (wr_data[NUM_IRQ-1:0] & bmask[NUM_IRQ-1:0]) : '0;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ctrl_q <= '0;
      sel_q  <= '0;
      isr_q  <= '0;
      ier_q  <= '0;
    end else begin
      if (wr_ctrl) ctrl_q <= (ctrl_q & ~bmask) | (wr_data & bmask);
      if (wr_sel)  sel_q  <= wr_data[SEL_W-1:0];
      if (wr_ier)  ier_q  <= (ier_q & ~bmask[NUM_IRQ-1:0]) |
                             (wr_data[NUM_IRQ-1:0] & bmask[NUM_IRQ-1:0]);
      isr_q <= (isr_q & ~clr) | irq_evt;
    end
  end

  always_comb begin
    rd_data = '0;
    unique case (idx)
      REG_CTRL: rd_data = ctrl_q;
      REG_SEL:  rd_data[SEL_W-1:0]   = sel_q;
      REG_ISR:  rd_data[NUM_IRQ-1:0] = isr_q;
      REG_IER:  rd_data[NUM_IRQ-1:0] = ier_q;
    endcase
  end

  assign sel_code = sel_q;
  assign irq_n    = !(ctrl_q[0] && |(isr_q & ier_q));

  // R7: flags only drop through a write to the flag register
  assert_isr_sticky_R7: assert property (@(posedge clk) disable iff (!rst_n)
    !wr_isr |=> ((isr_q & $past(isr_q)) == $past(isr_q)));
  // R7: an event always leaves its flag set
  assert_evt_sets_R7: assert property (@(posedge clk) disable iff (!rst_n)
    |irq_evt |=> ((isr_q & $past(irq_evt)) == $past(irq_evt)));
  // R5: control only moves on a write
  assert_ctrl_stable_R5: assert property (@(posedge clk) disable iff (!rst_n)
    !wr_ctrl |=> $stable(ctrl_q));
endmodule

// File: rtl/mbb_bridge.sv
module mbb_bridge
  import mbb_pkg::*;
#(
  parameter int unsigned DW      = 32,
  parameter int unsigned NUM_IRQ = 8,
  parameter int unsigned SEL_W   = 4,
  parameter int unsigned NUM_EXT = 7,
  localparam int unsigned NB     = DW / 8
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic [DW-1:0]      ad_i,
  output logic [DW-1:0]      ad_o,
  output logic               ad_oe,
  input  logic               ale,
  input  logic               cs_n,
  input  logic               rnw,
  input  logic               oe_n,
  input  logic [NB-1:0]      bwe_n,
  output logic               ta_n,
  output logic               irq_n,
  input  logic [NUM_IRQ-1:0] irq_evt,
  output logic               ee_sel_n,
  output logic [NUM_EXT-1:0] ext_sel_n
);
  reg_idx_e          idx;
  logic              wr_stb;
  logic [NB-1:0]     wr_be;
  logic [DW-1:0]     wr_data;
  logic              drive_en;
  logic [DW-1:0]     rd_data;
  logic [SEL_W-1:0]  sel_code;

  mbb_bus_ctrl #(.DW(DW)) bus_i (
    .clk(clk), .rst_n(rst_n), .ad_i(ad_i), .ale(ale), .cs_n(cs_n),
    .rnw(rnw), .oe_n(oe_n), .bwe_n(bwe_n), .idx(idx), .wr_stb(wr_stb),
    .wr_be(wr_be), .wr_data(wr_data), .drive_en(drive_en), .ta_n(ta_n)
  );

  mbb_regs #(.DW(DW), .NUM_IRQ(NUM_IRQ), .SEL_W(SEL_W)) regs_i (
    .clk(clk), .rst_n(rst_n), .idx(idx), .wr_stb(wr_stb), .wr_be(wr_be),
    .wr_data(wr_data), .irq_evt(irq_evt), .rd_data(rd_data),
    .sel_code(sel_code), .irq_n(irq_n)
  );

  mbb_sel_decode #(.CODE_W(SEL_W), .NUM_EXT(NUM_EXT)) dec_i (
    .clk(clk), .rst_n(rst_n), .code(sel_code),
    .ee_sel_n(ee_sel_n), .ext_sel_n(ext_sel_n)
  );

  assign ad_oe = drive_en;
  assign ad_o  = drive_en ? rd_data : '0;

  // R2: bus released whenever output-enable is high
  assert_hiz_oe_R2: assert property (@(posedge clk) disable iff (!rst_n)
    oe_n |-> !ad_oe);
  // R9, R3: a write acknowledge implies the write strobe came with chip select
  assert_wr_cs_R9: assert property (@(posedge clk) disable iff (!rst_n)
    wr_stb |-> !cs_n);
  // R2: reset keeps the bus undriven
  always_comb begin
    if (!rst_n) assert_hiz_reset_R2: assert (!ad_oe);
  end
endmodule

// File: tb/mbb_bridge_tb.sv
module mbb_bridge_tb_top;
  localparam int unsigned CLK_PERIOD = 10;
  localparam int unsigned NVEC = 10;
  // {wr, addr, data, byte-enables, expected read}
  localparam logic [100:0] VEC [NVEC] = '{
    {1'b1, 32'h0000_0000, 32'hA5A5_5A5A, 4'hF, 32'h0},
    {1'b0, 32'h0000_0000, 32'h0,         4'h0, 32'hA5A5_5A5A},
    {1'b1, 32'h0000_0100, 32'h1111_2222, 4'h4, 32'h0},
    {1'b0, 32'h0000_0000, 32'h0,         4'h0, 32'hA511_5A5A},
    {1'b1, 32'h0000_000C, 32'hFFFF_FF3C, 4'h1, 32'h0},
    {1'b0, 32'h0000_000C, 32'h0,         4'h0, 32'h0000_003C},
    {1'b1, 32'h0000_0004, 32'h0000_0005, 4'hF, 32'h0},
    {1'b0, 32'h0000_0004, 32'h0,         4'h0, 32'h0000_0005},
    {1'b1, 32'h0000_0008, 32'h0000_00FF, 4'hF, 32'h0},
    {1'b0, 32'h0000_0008, 32'h0,         4'h0, 32'h0}
  };

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [31:0] ad_i = '0;
  logic [31:0] ad_o;
  logic        ad_oe;
  logic        ale = 1'b0, cs_n = 1'b1, rnw = 1'b1, oe_n = 1'b1;
  logic [3:0]  bwe_n = 4'hF;
  logic        ta_n, irq_n, ee_sel_n;
  logic [7:0]  irq_evt = '0;
  logic [6:0]  ext_sel_n;
  int checks = 0;
  int errors = 0;

  always #(CLK_PERIOD / 2) clk = ~clk;

  mbb_bridge dut_i (
    .clk(clk), .rst_n(rst_n), .ad_i(ad_i), .ad_o(ad_o), .ad_oe(ad_oe),
    .ale(ale), .cs_n(cs_n), .rnw(rnw), .oe_n(oe_n), .bwe_n(bwe_n),
    .ta_n(ta_n), .irq_n(irq_n), .irq_evt(irq_evt),
    .ee_sel_n(ee_sel_n), .ext_sel_n(ext_sel_n)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic access(input bit wr, input logic [31:0] addr, input logic [31:0] data,
                        input logic [3:0] be, input logic [31:0] exp,
                        input logic [7:0] evt, input string req);
    @(negedge clk);
    cs_n = 1'b0; ale = 1'b1; ad_i = addr;
    @(negedge clk);
    ale = 1'b0;
    if (wr) begin
      ad_i = data; rnw = 1'b0; bwe_n = ~be; irq_evt = evt;
    end else begin
      ad_i = 32'hDEAD_BEEF; rnw = 1'b1; oe_n = 1'b0;
    end
    #1 chk("R2 drive enable in data phase", {31'b0, ad_oe}, {31'b0, !wr});
    @(negedge clk);
    irq_evt = '0;
    chk("R3 acknowledge low after first edge", {31'b0, ta_n}, 32'h0);
    if (!wr) chk(req, ad_o, exp);
    @(negedge clk);
    chk("R3 acknowledge back high", {31'b0, ta_n}, 32'h1);
    cs_n = 1'b1; oe_n = 1'b1; bwe_n = 4'hF; rnw = 1'b1;
    #1 chk("R2 released after access", {31'b0, ad_oe}, 32'h0);
  endtask

  task automatic set_sel(input logic [3:0] code);
    access(1'b1, 32'h4, {28'b0, code}, 4'hF, 32'h0, 8'h0, "R6");
    @(negedge clk);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    errors++;
    $display("FAIL watchdog expired actual=running expected=done");
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    // Reset state, with a read requested on the bus (R2, R5, R6, R8)
    cs_n = 1'b0; rnw = 1'b1; oe_n = 1'b0;
    repeat (3) @(negedge clk);
    chk("R2 undriven in reset", {31'b0, ad_oe}, 32'h0);
    chk("R3 no acknowledge in reset", {31'b0, ta_n}, 32'h1);
    chk("R8 no interrupt in reset", {31'b0, irq_n}, 32'h1);
    chk("R6 no select in reset", {24'b0, ee_sel_n, ext_sel_n}, 32'hFF);
    cs_n = 1'b1; oe_n = 1'b1;
    @(negedge clk);
    rst_n = 1'b1;
    access(1'b0, 32'h0, 32'h0, 4'h0, 32'h0, 8'h0, "R5 control resets to zero");

    for (int i = 0; i < NVEC; i++) begin
      access(VEC[i][100], VEC[i][99:68], VEC[i][67:36], VEC[i][35:32],
             VEC[i][31:0], 8'h0, "R1 R4 R5 table readback");
    end

    // R1: upper address bits ignored, data phase cannot move the index
    access(1'b0, 32'hFFFF_FFF4, 32'h0, 4'h0, 32'h5, 8'h0, "R1 aliased select read");

    // R6: decode of select codes
    chk("R6 code 5", {24'b0, ee_sel_n, ext_sel_n}, 32'hF7);
    set_sel(4'd1); chk("R6 code 1", {24'b0, ee_sel_n, ext_sel_n}, 32'h7F);
    set_sel(4'd8); chk("R6 code 8", {24'b0, ee_sel_n, ext_sel_n}, 32'hBF);
    set_sel(4'd2); chk("R6 code 2", {24'b0, ee_sel_n, ext_sel_n}, 32'hFE);
    set_sel(4'd9); chk("R6 code 9", {24'b0, ee_sel_n, ext_sel_n}, 32'hFF);
    set_sel(4'd0); chk("R6 code 0", {24'b0, ee_sel_n, ext_sel_n}, 32'hFF);

    // R9: strobes with chip select high
    @(negedge clk);
    ale = 1'b1; ad_i = 32'h0;
    @(negedge clk);
    ale = 1'b0; ad_i = 32'h0000_0001; rnw = 1'b0; bwe_n = 4'h0;
    @(negedge clk);
    chk("R9 no acknowledge without select", {31'b0, ta_n}, 32'h1);
    @(negedge clk);
    rnw = 1'b1; oe_n = 1'b0;
    #1 chk("R9 no drive without select", {31'b0, ad_oe}, 32'h0);
    @(negedge clk);
    oe_n = 1'b1; bwe_n = 4'hF;
    access(1'b0, 32'h0, 32'h0, 4'h0, 32'hA511_5A5A, 8'h0, "R9 control unchanged");

    // R7, R8: flags, mask and master enable
    @(negedge clk); irq_evt = 8'h04;
    @(negedge clk); irq_evt = 8'h00;
    chk("R8 masked by control bit 0", {31'b0, irq_n}, 32'h1);
    access(1'b0, 32'h8, 32'h0, 4'h0, 32'h4, 8'h0, "R7 flag set by event");
    access(1'b1, 32'h0, 32'h1, 4'h1, 32'h0, 8'h0, "R8");
    chk("R8 interrupt raised", {31'b0, irq_n}, 32'h0);
    @(negedge clk); irq_evt = 8'h01;
    @(negedge clk); irq_evt = 8'h00;
    access(1'b0, 32'h8, 32'h0, 4'h0, 32'h5, 8'h0, "R7 second flag held");
    access(1'b1, 32'h8, 32'h4, 4'hF, 32'h0, 8'h0, "R7");
    chk("R8 unmasked flag alone gives no interrupt", {31'b0, irq_n}, 32'h1);
    access(1'b0, 32'h8, 32'h0, 4'h0, 32'h1, 8'h0, "R7 clear by writing one");
    access(1'b1, 32'h8, 32'h1, 4'hF, 32'h0, 8'h01, "R7");
    access(1'b0, 32'h8, 32'h0, 4'h0, 32'h1, 8'h0, "R7 set wins over clear");
    access(1'b1, 32'h8, 32'h1, 4'hE, 32'h0, 8'h0, "R4");
    access(1'b0, 32'h8, 32'h0, 4'h0, 32'h1, 8'h0, "R4 clear needs lane 0 enable");

    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule